// File: doc/BRIEF.md
# Protected Message Transmitter

This block builds one protected serial message and shifts it out on a single line. After a START request it pulls bytes from an 8-bit parallel bus, one take pulse per byte. Each byte goes out least significant bit first. A trailing redundancy field, computed bit by bit over the data bytes, follows the last byte. The message length is set by a 2-bit length code. The code picks one of three fixed byte counts, or a variable count. In the variable case the count travels at the head of the message inside a self-checking size byte.

Two line modes are supported. In asynchronous mode every serial bit lasts 32 clocks and the message opens with a start bit. In synchronous mode every bit lasts one clock, there is no start bit, and a framing output marks the bits of the message instead. A distance select picks a short (7-bit) or a long (15-bit) redundancy field. The mode inputs are captured when a message is accepted. The line rests high whenever no message is being sent.

Top module: `protected_msg_tx`

## Requirements
- R1: The length code sets the data byte count: code 2'b11 gives 6 bytes, 2'b01 gives 4, 2'b10 gives 2, and 2'b00 selects variable length. Exactly one take pulse is issued per byte fetched from the bus.
- R2: In variable mode the first byte fetched is the size source, and the message begins with a size byte built from it. Bus bits 0,1,2 (C,B,A) are copied to size bits 0,1,2. Size bit 3 is C xor B xor A. Size bits 4..7 are the bitwise complement of size bits 0..3. The count that follows is 4C+2B+A, and zero is allowed.
- R3: With a fixed length code no size byte is sent, and the first data byte follows at once (after the start bit in asynchronous mode).
- R4: After the last data byte a redundancy field is sent, most significant bit first. It is 7 bits with generator x^7+x^6+x^5+x^2+1 when the distance select is low. It is 15 bits with generator x^15+x^14+x^11+x^10+x^7+x^6+x^2+1 when the select is high. The register is cleared at message start, and only data bits are fed into it.
- R5: In asynchronous mode a single 0 start bit comes first and every bit lasts 32 clocks. In synchronous mode there is no start bit and every bit lasts one clock.
- R6: In synchronous mode the framing output is high during every message bit. In asynchronous mode it stays low.
- R7: Each data byte is sent least significant bit first. The take pulse is one clock long, and it is high in the cycle that ends at the edge where bit 0 of that byte appears on the line. The bus is sampled at that edge.
- R8: BUSY rises at the edge that accepts START. The first bit appears one edge later. BUSY falls one bit period after the last bit begins, and at that edge the line returns high. The line is high whenever BUSY is low.
- R9: A message is accepted only after START has been seen low while idle. A START held high does not retrigger a message, and neither does a START that is already high when reset is released.
- R10: During reset the line is high and BUSY, take and framing are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Message request |
| len_code_i | input | 2 | Length code |
| hd6_i | input | 1 | Distance select: 0 gives a short field, 1 a long field |
| async_i | input | 1 | 1 selects asynchronous mode, 0 synchronous |
| data_i | input | 8 | Parallel byte bus |
| line_o | output | 1 | Serial message line |
| busy_o | output | 1 | Message in progress |
| take_o | output | 1 | Byte take pulse |
| msync_o | output | 1 | Message framing (synchronous mode) |

## Verification
START is driven before edge E0. BUSY is checked at the falling clock edge after E0, since it rises at E0 itself. Bit k of the message is launched at edge E0+1+k·B, where B is 32 or 1, and the bench samples it at the falling edge that follows. Each bit is therefore read in the middle of its window, together with the framing output. The bench then waits exactly B rising edges before it samples the next bit. The falling edge after E0+1+N·B is where BUSY must already be low and the line high. A separate process sees each take pulse at a falling edge and swaps in the next bus byte just after the following rising edge, so every byte is in place at the edge that consumes it.

// File: rtl/txp_pkg.sv
package txp_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_SIZE,
        PH_DATA,
        PH_RED,
        PH_END
    } phase_e;

    // regenerate a parity-protected size byte from bus bits {A,B,C}
    function automatic logic [BYTE_W-1:0] size_byte(input logic [2:0] cba);
        logic par;
        par = ^cba;
        return {~{par, cba}, par, cba};
    endfunction

    // count = 4*C + 2*B + A, with C in bus bit 0
    function automatic logic [2:0] size_count(input logic [2:0] cba);
        return {cba[0], cba[1], cba[2]};
    endfunction

endpackage

// File: rtl/txp_bit_timer.sv
module txp_bit_timer #(
    parameter int OVERSAMPLE = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    input  logic async_i,
    input  logic restart_i,
    output logic tick_o
);
    localparam int DIV_W = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
    localparam logic [DIV_W-1:0] LAST = DIV_W'(OVERSAMPLE - 1);

    logic [DIV_W-1:0] div_d, div_q;

    always_comb begin
        tick_o = run_i && (!async_i || (div_q == LAST));
        div_d  = div_q;
        if (restart_i) begin
            div_d = LAST;
        end else if (run_i && async_i) begin
            div_d = tick_o ? '0 : div_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) div_q <= '0;
        else     div_q <= div_d;
    end
endmodule

// File: rtl/txp_crc.sv
module txp_crc #(
    parameter int                 W_LONG  = 15,
    parameter int                 W_SHORT = 7,
    parameter logic [W_LONG-1:0]  POLY_L  = 15'h4CC5,
    parameter logic [W_LONG-1:0]  POLY_S  = 15'h0065
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear_i,
    input  logic              en_i,
    input  logic              bit_i,
    input  logic              long_i,
    output logic [W_LONG-1:0] crc_o
);
    localparam logic [W_LONG-1:0] MASK_S = {{(W_LONG-W_SHORT){1'b0}}, {W_SHORT{1'b1}}};

    logic [W_LONG-1:0] crc_d, crc_q;
    logic              top, fb;
    logic [W_LONG-1:0] shifted;

    always_comb begin
        top     = long_i ? crc_q[W_LONG-1] : crc_q[W_SHORT-1];
        fb      = bit_i ^ top;
        shifted = {crc_q[W_LONG-2:0], 1'b0} ^ (fb ? (long_i ? POLY_L : POLY_S) : '0);
        crc_d   = crc_q;
        if (clear_i) begin
            crc_d = '0;
        end else if (en_i) begin
            crc_d = long_i ? shifted : (shifted & MASK_S);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) crc_q <= '0;
        else     crc_q <= crc_d;
    end

    assign crc_o = crc_q;
endmodule

// File: rtl/txp_start_arm.sv
module txp_start_arm (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic busy_i,
    output logic fire_o
);
    logic armed_d, armed_q;

    always_comb begin
        fire_o  = start_i && armed_q && !busy_i;
        armed_d = armed_q;
        if (fire_o)                    armed_d = 1'b0;
        else if (!start_i && !busy_i)  armed_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) armed_q <= 1'b0;
        else     armed_q <= armed_d;
    end
endmodule

// File: rtl/protected_msg_tx.sv
module protected_msg_tx
    import txp_pkg::*;
#(
    parameter int                 OVERSAMPLE  = 32,
    parameter int                 CRC_LONG_W  = 15,
    parameter int                 CRC_SHORT_W = 7,
    parameter logic [CRC_LONG_W-1:0] POLY_LONG  = 15'h4CC5,
    parameter logic [CRC_LONG_W-1:0] POLY_SHORT = 15'h0065,
    parameter int                 COUNT_HI    = 6,
    parameter int                 COUNT_MID   = 4,
    parameter int                 COUNT_LO    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [1:0]        len_code_i,
    input  logic              hd6_i,
    input  logic              async_i,
    input  logic [BYTE_W-1:0] data_i,
    output logic              line_o,
    output logic              busy_o,
    output logic              take_o,
    output logic              msync_o
);
    localparam int BIT_W  = $clog2(CRC_LONG_W + 1);
    localparam int LEFT_W = 3;
    localparam logic [BIT_W-1:0] LAST_BYTE_BIT = BIT_W'(BYTE_W - 1);
    localparam logic [BIT_W-1:0] TOP_LONG      = BIT_W'(CRC_LONG_W - 1);
    localparam logic [BIT_W-1:0] TOP_SHORT     = BIT_W'(CRC_SHORT_W - 1);

    typedef struct packed {
        phase_e             phase;
        logic [BIT_W-1:0]   bitn;
        logic [LEFT_W-1:0]  left;
        logic [BYTE_W-1:0]  sh;
        logic               line;
        logic               busy;
        logic               msync;
        logic               async_m;
        logic               hd6;
        logic               varlen;
    } st_t;

    localparam st_t ST_RESET = '{
        phase:   PH_IDLE,
        bitn:    '0,
        left:    '0,
        sh:      '0,
        line:    1'b1,
        busy:    1'b0,
        msync:   1'b0,
        async_m: 1'b0,
        hd6:     1'b0,
        varlen:  1'b0
    };

    st_t s_d, s_q;

    logic                  fire, tick;
    logic                  crc_en, crc_bit;
    logic [CRC_LONG_W-1:0] crc_val;
    logic [BYTE_W-1:0]     sz;
    logic                  bit_now;
    logic [BIT_W-1:0]      red_top, red_idx;
    logic [LEFT_W-1:0]     fixed_cnt;

    txp_start_arm u_arm (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .busy_i  (s_q.busy),
        .fire_o  (fire)
    );

    txp_bit_timer #(.OVERSAMPLE(OVERSAMPLE)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .run_i     (s_q.busy),
        .async_i   (s_q.async_m),
        .restart_i (fire),
        .tick_o    (tick)
    );

    txp_crc #(
        .W_LONG  (CRC_LONG_W),
        .W_SHORT (CRC_SHORT_W),
        .POLY_L  (POLY_LONG),
        .POLY_S  (POLY_SHORT)
    ) u_crc (
        .clk     (clk),
        .rst     (rst),
        .clear_i (fire),
        .en_i    (crc_en),
        .bit_i   (crc_bit),
        .long_i  (s_q.hd6),
        .crc_o   (crc_val)
    );

    always_comb begin
        unique case (len_code_i)
            2'b11:   fixed_cnt = LEFT_W'(COUNT_HI);
            2'b01:   fixed_cnt = LEFT_W'(COUNT_MID);
            2'b10:   fixed_cnt = LEFT_W'(COUNT_LO);
            default: fixed_cnt = '0;
        endcase
    end

    always_comb begin
        s_d     = s_q;
        crc_en  = 1'b0;
        crc_bit = 1'b0;
        sz      = size_byte(data_i[2:0]);
        bit_now = (s_q.bitn == '0) ? data_i[0] : s_q.sh[s_q.bitn[2:0]];
        red_top = s_q.hd6 ? TOP_LONG : TOP_SHORT;
        red_idx = red_top - s_q.bitn;

        if (!s_q.busy) begin
            if (fire) begin
                s_d.busy    = 1'b1;
                s_d.async_m = async_i;
                s_d.hd6     = hd6_i;
                s_d.varlen  = (len_code_i == 2'b00);
                s_d.left    = fixed_cnt;
                s_d.bitn    = '0;
                if (async_i)                  s_d.phase = PH_START;
                else if (len_code_i == 2'b00) s_d.phase = PH_SIZE;
                else                          s_d.phase = PH_DATA;
            end
        end else if (tick) begin
            unique case (s_q.phase)
                PH_START: begin
                    s_d.line  = 1'b0;
                    s_d.bitn  = '0;
                    s_d.phase = s_q.varlen ? PH_SIZE : PH_DATA;
                end
                PH_SIZE: begin
                    if (s_q.bitn == '0) begin
                        s_d.line = sz[0];
                        s_d.sh   = sz;
                        s_d.left = size_count(data_i[2:0]);
                    end else begin
                        s_d.line = s_q.sh[s_q.bitn[2:0]];
                    end
                    if (s_q.bitn == LAST_BYTE_BIT) begin
                        s_d.bitn  = '0;
                        s_d.phase = (s_q.left == '0) ? PH_RED : PH_DATA;
                    end else begin
                        s_d.bitn = s_q.bitn + 1'b1;
                    end
                end
                PH_DATA: begin
                    if (s_q.bitn == '0) s_d.sh = data_i;
                    s_d.line = bit_now;
                    crc_en   = 1'b1;
                    crc_bit  = bit_now;
                    if (s_q.bitn == LAST_BYTE_BIT) begin
                        s_d.bitn  = '0;
                        s_d.left  = s_q.left - 1'b1;
                        s_d.phase = (s_q.left == LEFT_W'(1)) ? PH_RED : PH_DATA;
                    end else begin
                        s_d.bitn = s_q.bitn + 1'b1;
                    end
                end
                PH_RED: begin
                    s_d.line = crc_val[red_idx];
                    if (s_q.bitn == red_top) begin
                        s_d.phase = PH_END;
                        s_d.bitn  = '0;
                    end else begin
                        s_d.bitn = s_q.bitn + 1'b1;
                    end
                end
                PH_END: begin
                    s_d.busy  = 1'b0;
                    s_d.line  = 1'b1;
                    s_d.msync = 1'b0;
                    s_d.phase = PH_IDLE;
                end
                default: begin
                    s_d.phase = PH_IDLE;
                end
            endcase
            if (s_q.phase inside {PH_START, PH_SIZE, PH_DATA, PH_RED}) begin
                s_d.msync = !s_q.async_m;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= ST_RESET;
        else     s_q <= s_d;
    end

    assign line_o  = s_q.line;
    assign busy_o  = s_q.busy;
    assign msync_o = s_q.msync;
    assign take_o  = s_q.busy && tick && (s_q.bitn == '0) &&
                     ((s_q.phase == PH_SIZE) || (s_q.phase == PH_DATA));
endmodule

module txp_checker (
    input logic clk,
    input logic rst,
    input logic start_i,
    input logic line_o,
    input logic busy_o,
    input logic take_o,
    input logic msync_o
);
    assert_idle_line_high_R8: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> line_o);

    assert_take_inside_busy_R7: assert property (@(posedge clk) disable iff (rst)
        take_o |-> busy_o);

    assert_take_single_cycle_R7: assert property (@(posedge clk) disable iff (rst)
        take_o |=> !take_o);

    assert_msync_inside_busy_R6: assert property (@(posedge clk) disable iff (rst)
        msync_o |-> busy_o);

    assert_busy_needs_start_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(start_i));
endmodule

bind protected_msg_tx txp_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .line_o  (line_o),
    .busy_o  (busy_o),
    .take_o  (take_o),
    .msync_o (msync_o)
);

// File: tb/sim_protected_msg_tx.sv
module sim_protected_msg_tx;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;

    // {async, hd6, len_code[1:0], size bits {A,B,C}[2:0], seed[7:0]}
    localparam logic [14:0] VECS [NVEC] = '{
        {1'b0, 1'b0, 2'b11, 3'b000, 8'h5A},
        {1'b0, 1'b1, 2'b01, 3'b000, 8'hC3},
        {1'b0, 1'b0, 2'b10, 3'b000, 8'h0F},
        {1'b0, 1'b1, 2'b00, 3'b101, 8'h91},
        {1'b1, 1'b0, 2'b00, 3'b110, 8'h27},
        {1'b1, 1'b1, 2'b10, 3'b000, 8'hE4},
        {1'b0, 1'b1, 2'b00, 3'b000, 8'h3C},
        {1'b1, 1'b0, 2'b11, 3'b000, 8'h71}
    };

    logic clk = 1'b0;
    logic rst, start_i, hd6_i, async_i;
    logic [1:0] len_code_i;
    logic [7:0] data_i;
    logic line_o, busy_o, take_o, msync_o;

    int nvec = 0;
    int nbad = 0;
    logic exp_b [128];
    int   exp_t [128];
    int   nbits;
    logic [7:0] feed [8];
    int   nbytes;
    int   feed_idx;
    int   take_cnt;
    bit   done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    protected_msg_tx u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .len_code_i(len_code_i),
        .hd6_i(hd6_i), .async_i(async_i), .data_i(data_i),
        .line_o(line_o), .busy_o(busy_o), .take_o(take_o), .msync_o(msync_o)
    );

    always @(negedge clk) begin
        if (take_o && !rst) begin
            take_cnt++;
            @(posedge clk);
            #1;
            if (feed_idx < 8) data_i = feed[feed_idx];
            feed_idx++;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        nvec++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic string tag_name(input int t);
        case (t)
            2: return "R2 size bit";
            3: return "R3 first data byte";
            4: return "R4 redundancy bit";
            5: return "R5 start bit";
            default: return "R7 data bit";
        endcase
    endfunction

    task automatic push(input logic b, input int t);
        exp_b[nbits] = b;
        exp_t[nbits] = t;
        nbits++;
    endtask

    task automatic build(input logic [14:0] v);
        logic [2:0]  szb;
        logic [7:0]  seed, b, szbyte;
        logic [14:0] c;
        logic        fb, par;
        int          n, off;
        szb = v[10:8];
        seed = v[7:0];
        nbits = 0;
        if (v[14]) push(1'b0, 5);
        if (v[12:11] == 2'b00) begin
            n = 4*szb[0] + 2*szb[1] + szb[2];
            feed[0] = {seed[7:3], szb};
            par = szb[0] ^ szb[1] ^ szb[2];
            szbyte = {~par, ~szb[2], ~szb[1], ~szb[0], par, szb[2], szb[1], szb[0]};
            for (int i = 0; i < 8; i++) push(szbyte[i], 2);
            off = 1;
        end else begin
            n = (v[12:11] == 2'b11) ? 6 : (v[12:11] == 2'b01) ? 4 : 2;
            off = 0;
        end
        c = '0;
        for (int j = 0; j < n; j++) begin
            b = seed + 8'(j * 53);
            feed[off + j] = b;
            for (int i = 0; i < 8; i++) begin
                push(b[i], (off == 0 && j == 0) ? 3 : 7);
                fb = b[i] ^ (v[13] ? c[14] : c[6]);
                c = {c[13:0], 1'b0} ^ (fb ? (v[13] ? 15'h4CC5 : 15'h0065) : 15'h0);
                if (!v[13]) c = c & 15'h007F;
            end
        end
        for (int i = (v[13] ? 14 : 6); i >= 0; i--) push(c[i], 4);
        nbytes = off + n;
    endtask

    task automatic run_msg(input logic [14:0] v, input bit hold);
        int bper;
        build(v);
        bper = v[14] ? 32 : 1;
        @(negedge clk);
        async_i = v[14];
        hd6_i = v[13];
        len_code_i = v[12:11];
        data_i = feed[0];
        feed_idx = 1;
        take_cnt = 0;
        start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        if (!hold) start_i = 1'b0;
        check(busy_o === 1'b1, "R8 busy rise", int'(busy_o), 1);
        @(posedge clk);
        for (int k = 0; k < nbits; k++) begin
            @(negedge clk);
            check(line_o === exp_b[k], tag_name(exp_t[k]), int'(line_o), int'(exp_b[k]));
            check(msync_o === !v[14], "R6 framing", int'(msync_o), int'(!v[14]));
            repeat (bper) @(posedge clk);
        end
        @(negedge clk);
        check(busy_o === 1'b0, "R8 busy fall", int'(busy_o), 0);
        check(line_o === 1'b1, "R8 idle line", int'(line_o), 1);
        check(take_cnt == nbytes, "R1 take count", take_cnt, nbytes);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        start_i = 1'b1;
        hd6_i = 1'b0;
        async_i = 1'b0;
        len_code_i = 2'b10;
        data_i = 8'h00;
        feed_idx = 0;
        take_cnt = 0;
        repeat (3) @(negedge clk);
        check(line_o === 1'b1, "R10 line", int'(line_o), 1);
        check(busy_o === 1'b0, "R10 busy", int'(busy_o), 0);
        check(take_o === 1'b0, "R10 take", int'(take_o), 0);
        check(msync_o === 1'b0, "R10 framing", int'(msync_o), 0);
        rst = 1'b0;
        repeat (20) @(negedge clk);
        check(busy_o === 1'b0, "R9 start high at reset release", int'(busy_o), 0);
        start_i = 1'b0;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) run_msg(VECS[i], 1'b0);

        // START held high across a whole message must not retrigger (R9)
        run_msg(VECS[2], 1'b1);
        repeat (40) @(negedge clk);
        check(busy_o === 1'b0, "R9 held start no retrigger", int'(busy_o), 0);
        check(line_o === 1'b1, "R9 held start line idle", int'(line_o), 1);
        start_i = 1'b0;
        @(negedge clk);
        start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o === 1'b1, "R9 retrigger after low", int'(busy_o), 1);
        repeat (200) @(negedge clk);
        check(busy_o === 1'b0, "R8 end of retriggered message", int'(busy_o), 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule